// File: doc/BRIEF.md
# Playback Divider and Table Length Search Engine

This block picks a pair (clock divider, table length) for a waveform player whose output frequency is the system clock divided by the divider and by the table length. When strobed with a target frequency, it sweeps the table length downward from its largest value. For each length it works out the nearest integer divider, the frequency that pair really produces, and how far that lies from the target. It keeps the closest pair seen so far.

The sweep ends early once a pair lands within a small error threshold. It also ends once the shortest allowed length has been tried. In either case the best pair and its error are published together with a one-cycle completion pulse.

All arithmetic uses one shared iterative restoring divider, so each length costs roughly two divider passes. The system clock rate, the fixed-point format, the length bounds and the threshold are parameters. The defaults are a 72 MHz clock, 8 fractional bits, lengths from 1024 down to 256, and a threshold of 3 LSB, which is about 0.01 Hz.

Top module: `fsearch_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `best_div`, `best_len` and `best_err` are all zero until the first search completes.
- R2: `target` is unsigned fixed point with FRAC fractional bits; bits [FRAC-1:0] are the fraction. For a length L the divider is round(CLK_HZ·2^FRAC / (target·L)), computed as floor((2·CLK_HZ·2^FRAC + target·L) / (2·target·L)). It is clamped to at least 1 and at most 2^DW−1.
- R3: The achieved frequency is floor(CLK_HZ·2^FRAC / (divider·L)) in the same format as `target`. The error is its absolute difference from `target`, saturated to 2^EW−1. The first pair evaluated is always kept. A later pair replaces the kept one only when its error is strictly lower, so on a tie the longer table wins.
- R4: The sweep starts at L = LEN_MAX. It stops right after a pair whose error is below THR LSB; that pair is then the one reported.
- R5: Otherwise L drops by one per step, down to and including LEN_MIN, after which the kept pair is reported; `best_len` always lies in [LEN_MIN, LEN_MAX].
- R6: A start with a zero target completes in the next cycle with `best_div` all ones, `best_len` = LEN_MAX and `best_err` all ones.
- R7: `done` is a single-cycle pulse that never coincides with a running search. `best_div`, `best_len` and `best_err` change only in the cycle in which `done` is high.
- R8: A `start` strobe that arrives while a search is running is ignored; the running search completes with the result of its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| target | input | TW | Target frequency, unsigned, FRAC fractional bits |
| best_div | output | DW | Chosen clock divider |
| best_len | output | clog2(LEN_MAX+1) | Chosen table length |
| best_err | output | EW | Absolute frequency error of the chosen pair |
| done | output | 1 | One-cycle pulse when the results update |

## Verification
On every cycle, the checker confirms four things. The published length stays inside its window, and a published divider is never zero. The result registers hold still outside the completion pulse, and that pulse never overlaps a running search. It also checks that a zero target completes at once with the saturated result. Whether the divider is rounded correctly, whether ties keep the longer table, and when the early exit and the floor take effect can only be shown by the bench. The bench compares complete searches for a spread of targets against an independent arithmetic model, and checks that a strobe arriving mid-search leaves the running search untouched.

// File: rtl/fsearch_pkg.sv
package fsearch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GO_A,
      ST_WAIT_A,
      ST_GO_B,
      ST_WAIT_B
   } fs_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fsearch_divu.sv
// Restoring divider: one quotient bit per cycle, WW cycles per operation.
module fsearch_divu #(
   parameter int WW = 45
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [WW-1:0] num,
   input  logic [WW-1:0] den,
   output logic [WW-1:0] quot,
   output logic          vld
);
   localparam int CNTW = $clog2(WW + 1);

   logic [WW-1:0]   rem_q, quo_q, den_q;
   logic [CNTW-1:0] cnt_q;
   logic            run_q;
   logic [WW:0]     shifted, diff;
   logic            fits;

   always_comb begin
      shifted = {rem_q, quo_q[WW-1]};
      diff    = shifted - {1'b0, den_q};
      fits    = shifted >= {1'b0, den_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         vld   <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CNTW'(WW);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? diff[WW-1:0] : shifted[WW-1:0];
            quo_q <= {quo_q[WW-2:0], fits};
            cnt_q <= cnt_q - CNTW'(1);
            if (cnt_q == CNTW'(1)) begin
               run_q <= 1'b0;
               vld   <= 1'b1;
            end
         end
      end
   end

   assign quot = quo_q;
endmodule

// File: rtl/fsearch_errsat.sv
// Absolute difference of two wide values, narrowed to EW bits with saturation.
module fsearch_errsat #(
   parameter int WW = 45,
   parameter int EW = 32
) (
   input  logic [WW-1:0] a,
   input  logic [WW-1:0] b,
   output logic [EW-1:0] err
);
   logic [WW-1:0] mag;

   assign mag = (a >= b) ? (a - b) : (b - a);

   generate
      if (WW > EW) begin : g_sat
         assign err = (|mag[WW-1:EW]) ? {EW{1'b1}} : mag[EW-1:0];
      end else begin : g_pass
         assign err = EW'(mag);
      end
   endgenerate
endmodule

// File: rtl/fsearch_engine.sv
module fsearch_engine
   import fsearch_pkg::*;
#(
   parameter int CLK_HZ  = 72_000_000,
   parameter int FRAC    = 8,
   parameter int TW      = 32,
   parameter int DW      = 32,
   parameter int EW      = 32,
   parameter int LEN_MAX = 1024,
   parameter int LEN_MIN = 256,
   parameter int THR     = 3,
   localparam int LW     = $clog2(LEN_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] target,
   output logic [DW-1:0] best_div,
   output logic [LW-1:0] best_len,
   output logic [EW-1:0] best_err,
   output logic          done
);
   localparam int CW = $clog2(CLK_HZ + 1);
   localparam int NW = CW + FRAC;
   localparam int WW = imax(imax(NW, TW + LW), DW + LW) + 2;
   localparam logic [WW-1:0] NUM_K = WW'(CLK_HZ) << FRAC;

   generate
      if (LEN_MIN < 1 || LEN_MIN > LEN_MAX) begin : g_bad_len
         $error("fsearch_engine: LEN_MIN must lie in 1..LEN_MAX");
      end
      if (THR < 1 || EW >= WW) begin : g_bad_width
         $error("fsearch_engine: THR must be positive and EW narrower than the work width");
      end
   endgenerate

   fs_state_e     state_q;
   logic [TW-1:0] tgt_q;
   logic [LW-1:0] len_q, blen_q;
   logic [DW-1:0] cdiv_q, bdiv_q;
   logic [EW-1:0] berr_q;
   logic          first_q;
   logic          busy;

   logic          div_go, div_vld;
   logic [WW-1:0] div_num, div_den, div_quot;
   logic [WW-1:0] prod_tl, prod_dl;
   logic [DW-1:0] q_div;
   logic [EW-1:0] cur_err;
   logic          better, stop;

   assign busy = (state_q != ST_IDLE);

   always_comb begin
      prod_tl = WW'(tgt_q) * WW'(len_q);
      prod_dl = WW'(cdiv_q) * WW'(len_q);
      div_go  = (state_q == ST_GO_A) || (state_q == ST_GO_B);
      if (state_q == ST_GO_A) begin
         div_num = (NUM_K << 1) + prod_tl;
         div_den = prod_tl << 1;
      end else begin
         div_num = NUM_K;
         div_den = prod_dl;
      end
   end

   fsearch_divu #(.WW(WW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (div_num),
      .den  (div_den),
      .quot (div_quot),
      .vld  (div_vld)
   );

   fsearch_errsat #(.WW(WW), .EW(EW)) u_err (
      .a  (div_quot),
      .b  (WW'(tgt_q)),
      .err(cur_err)
   );

   always_comb begin
      if (|div_quot[WW-1:DW])          q_div = {DW{1'b1}};
      else if (div_quot[DW-1:0] == '0) q_div = DW'(1);
      else                             q_div = div_quot[DW-1:0];
      better = first_q || (cur_err < berr_q);
      stop   = (cur_err < EW'(THR)) || (len_q == LW'(LEN_MIN));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tgt_q    <= '0;
         len_q    <= '0;
         cdiv_q   <= '0;
         bdiv_q   <= '0;
         blen_q   <= '0;
         berr_q   <= '0;
         first_q  <= 1'b0;
         best_div <= '0;
         best_len <= '0;
         best_err <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (target == '0) begin
                     best_div <= {DW{1'b1}};
                     best_len <= LW'(LEN_MAX);
                     best_err <= {EW{1'b1}};
                     done     <= 1'b1;
                  end else begin
                     tgt_q   <= target;
                     len_q   <= LW'(LEN_MAX);
                     first_q <= 1'b1;
                     state_q <= ST_GO_A;
                  end
               end
            end
            ST_GO_A: state_q <= ST_WAIT_A;
            ST_WAIT_A: begin
               if (div_vld) begin
                  cdiv_q  <= q_div;
                  state_q <= ST_GO_B;
               end
            end
            ST_GO_B: state_q <= ST_WAIT_B;
            ST_WAIT_B: begin
               if (div_vld) begin
                  first_q <= 1'b0;
                  if (better) begin
                     bdiv_q <= cdiv_q;
                     blen_q <= len_q;
                     berr_q <= cur_err;
                  end
                  if (stop) begin
                     best_div <= better ? cdiv_q  : bdiv_q;
                     best_len <= better ? len_q   : blen_q;
                     best_err <= better ? cur_err : berr_q;
                     done     <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else begin
                     len_q   <= len_q - LW'(1);
                     state_q <= ST_GO_A;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsearch_chk.sv
module fsearch_chk #(
   parameter int TW      = 32,
   parameter int DW      = 32,
   parameter int EW      = 32,
   parameter int LW      = 11,
   parameter int LEN_MAX = 1024,
   parameter int LEN_MIN = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [TW-1:0] target,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] best_div,
   input logic [LW-1:0] best_len,
   input logic [EW-1:0] best_err
);
   AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (best_len >= LW'(LEN_MIN)) && (best_len <= LW'(LEN_MAX))); // R5

   AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (best_div != '0)); // R2

   AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(best_div) && $stable(best_len) && $stable(best_err))); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7

   AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && target == '0) |=>
         (done && (&best_div) && (&best_err) && best_len == LW'(LEN_MAX))); // R6
endmodule

bind fsearch_engine fsearch_chk #(
   .TW(TW), .DW(DW), .EW(EW), .LW(LW), .LEN_MAX(LEN_MAX), .LEN_MIN(LEN_MIN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .target  (target),
   .busy    (busy),
   .done    (done),
   .best_div(best_div),
   .best_len(best_len),
   .best_err(best_err)
);

// File: tb/fsearch_engine_tb.sv
module fsearch_engine_tb;
   localparam int CLK_HZ = 72_000_000;
   localparam int FRAC   = 8;
   localparam int TW     = 32;
   localparam int DW     = 32;
   localparam int EW     = 32;
   localparam int LM     = 64;
   localparam int LN     = 16;
   localparam int THR    = 3;
   localparam int LW     = $clog2(LM + 1);

   localparam int NV = 6;
   // target (8 fractional bits), expected length (0 = model only), expected divider (0 = model only)
   localparam longint unsigned VEC_T [NV] = '{64'd256000, 64'd1280000000, 64'd1792,
                                              64'd12345678, 64'd3, 64'd1};
   localparam int VEC_L [NV] = '{64, 16, 0, 0, 0, 0};
   localparam int VEC_D [NV] = '{1125, 1, 0, 0, 0, 0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] target = '0;
   logic [DW-1:0] best_div;
   logic [LW-1:0] best_len;
   logic [EW-1:0] best_err;
   logic          done;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   fsearch_engine #(
      .CLK_HZ(CLK_HZ), .FRAC(FRAC), .TW(TW), .DW(DW), .EW(EW),
      .LEN_MAX(LM), .LEN_MIN(LN), .THR(THR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .target(target),
      .best_div(best_div), .best_len(best_len), .best_err(best_err), .done(done)
   );

   task automatic check(input bit ok, input string tag, input longint unsigned act,
                        input longint unsigned exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
         finish_run();
      end
   end

   // Arithmetic model written from R2..R5
   function automatic void model(input longint unsigned t, output longint unsigned d,
                                 output longint unsigned l, output longint unsigned e);
      longint unsigned k, den, dv, fx, er;
      longint unsigned dmax, emax;
      bit first;
      k = longint'(CLK_HZ) << FRAC;
      dmax = (64'd1 << DW) - 1;
      emax = (64'd1 << EW) - 1;
      first = 1'b1;
      d = 0; l = 0; e = 0;
      for (int len = LM; len >= LN; len--) begin
         den = t * longint'(len);
         dv  = (2 * k + den) / (2 * den);
         if (dv == 0) dv = 1;
         if (dv > dmax) dv = dmax;
         fx = k / (dv * longint'(len));
         er = (fx > t) ? fx - t : t - fx;
         if (er > emax) er = emax;
         if (first || er < e) begin
            d = dv; l = longint'(len); e = er;
         end
         first = 1'b0;
         if (er < THR) break;
      end
   endfunction

   task automatic pulse_start(input longint unsigned t);
      @(negedge clk);
      target = TW'(t);
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20000 && !seen; i++) begin
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
   endtask

   initial begin
      longint unsigned ed, el, ee;
      bit seen;
      logic [DW-1:0] hd;
      logic [LW-1:0] hl;
      logic [EW-1:0] he;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(done == 1'b0,   "R1 done in reset", done, 0);
      check(best_div == '0, "R1 div in reset", best_div, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(best_len == '0, "R1 len after reset", best_len, 0);
      check(best_err == '0, "R1 err after reset", best_err, 0);

      // Vector table: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         model(VEC_T[v], ed, el, ee);
         pulse_start(VEC_T[v]);
         wait_done(seen);
         check(seen, "R4 search completes", seen, 1);
         check(best_div == DW'(ed), "R2 divider", best_div, ed);
         check(best_len == LW'(el), "R5 length", best_len, el);
         check(best_err == EW'(ee), "R3 error", best_err, ee);
         if (VEC_L[v] != 0) begin
            check(best_len == LW'(VEC_L[v]), "R4 R5 known length", best_len, VEC_L[v]);
            check(best_div == DW'(VEC_D[v]), "R2 known divider", best_div, VEC_D[v]);
         end
         @(negedge clk);
         check(done == 1'b0, "R7 done lasts one cycle", done, 0);
      end

      // R6: zero target
      pulse_start(0);
      check(done == 1'b1, "R6 immediate done", done, 1);
      check(&best_div, "R6 divider all ones", best_div, {DW{1'b1}});
      check(best_len == LW'(LM), "R6 length max", best_len, LM);
      check(&best_err, "R6 error all ones", best_err, {EW{1'b1}});

      // R7 hold, R8 ignored start
      hd = best_div; hl = best_len; he = best_err;
      model(64'd1792, ed, el, ee);
      pulse_start(64'd1792);
      repeat (10) @(negedge clk);
      check(best_div == hd && best_len == hl && best_err == he,
            "R7 results hold while running", best_div, hd);
      pulse_start(64'd256000);
      wait_done(seen);
      check(seen, "R8 search completes", seen, 1);
      check(best_div == DW'(ed), "R8 divider of first target", best_div, ed);
      check(best_len == LW'(el), "R8 length of first target", best_len, el);
      @(negedge clk);
      repeat (300) @(negedge clk);
      check(done == 1'b0, "R8 no second search", done, 0);
      check(best_len == LW'(el), "R8 results unchanged", best_len, el);

      finish_run();
   end
endmodule